// File: doc/BRIEF.md
# Interrupt Priority and Preemption Unit

This block is the priority logic of one processor's interrupt interface. Each cycle it receives the highest pending candidate as a priority and an ID. It compares that candidate against a programmable priority mask and against the priority of the interrupt that is running now. From that comparison it drives a single interrupt request line to the processor.

An acknowledge accepts the signalled interrupt. It returns the interrupt's ID and pushes the interrupt's priority and ID onto a last-in-first-out stack of active priorities. The top of that stack is the running priority. An end-of-interrupt names an ID and pops the stack when that ID matches the top entry; this pop is the priority drop. Any other end-of-interrupt raises an error pulse and leaves the stack as it was.

Two settings shape the comparison. Only the upper `PRIO_BITS` bits of any priority are kept. A binary-point setting then marks how many low bits are subpriority, and subpriority bits take no part in preemption.

Top module: `irq_prio_unit`

## Requirements
- R1: After a synchronous active-low reset, `irq_req` is 0, `running_prio` is 0xFF (idle, stack empty), `ack_id` is 1023 and `eoi_err` is 0.
- R2: Only the upper `PRIO_BITS` bits of a priority are used (default 5, so the low 3 bits are ignored). A priority taken onto the stack is reported on `running_prio` in this truncated form, with the low bits zero.
- R3: `irq_req` is asserted only if the truncated candidate priority is numerically strictly lower than the truncated `prio_mask`. An equal value blocks the request.
- R4: With the stack empty, `irq_req` equals `cand_valid` whenever the mask test of R3 passes. The signal is combinational from the inputs.
- R5: With the stack not empty, `irq_req` also requires the candidate's group priority to be numerically strictly lower than the running priority's group priority. The group priority is the truncated priority with its low `bin_point` bits cleared (`bin_point` ranges 0..7).
- R6: An `ack` in a cycle where `irq_req` is 1 and `eoi` is 0 pushes the candidate. In the following cycle, `ack_id` equals `cand_id` and `running_prio` equals the truncated candidate priority.
- R7: An `ack` in a cycle where `irq_req` is 0 makes `ack_id` read 1023 in the following cycle and changes neither the stack nor `running_prio`.
- R8: When the stack holds `STACK_DEPTH` entries (default 8), `irq_req` stays 0 even for a candidate that would otherwise preempt, and an `ack` returns 1023.
- R9: An `eoi` whose `eoi_id` equals the ID on top of the stack pops that entry. In the following cycle, `running_prio` is the previous entry's priority, or 0xFF if the stack is now empty, and `eoi_err` is 0.
- R10: An `eoi` whose `eoi_id` differs from the top-of-stack ID drives `eoi_err` to 1 for the following cycle and leaves the stack and `running_prio` unchanged.
- R11: An `eoi` while the stack is empty drives `eoi_err` to 1 for the following cycle and has no other effect.
- R12: When `ack` and `eoi` are asserted in the same cycle, the `eoi` is handled. The `ack` is ignored and returns 1023, even if `irq_req` was 1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cand_valid | input | 1 | A pending candidate is present |
| cand_prio | input | 8 | Candidate priority; 0 is the highest |
| cand_id | input | 10 | Candidate interrupt ID |
| prio_mask | input | 8 | Priority mask for this processor |
| bin_point | input | 3 | Number of low subpriority bits |
| ack | input | 1 | Acknowledge strobe |
| eoi | input | 1 | End-of-interrupt strobe |
| eoi_id | input | 10 | ID retired by the end-of-interrupt |
| irq_req | output | 1 | Interrupt request to the processor |
| ack_id | output | 10 | ID returned by the last acknowledge; 1023 when nothing was accepted |
| running_prio | output | 8 | Current running priority; 0xFF when idle |
| eoi_err | output | 1 | One-cycle pulse for a rejected end-of-interrupt |

## Verification
The hardest state to reach from the ports is a full stack. It needs `STACK_DEPTH` nested acknowledges, and each one must preempt the one before it, so every pushed priority has to be strictly higher than the last. The bench uses the widest group (binary point 0) and steps the priority down by one truncation step per push, from 0x40 to 0x08. That leaves the priority 0x00, which would still preempt. The bench offers it to show that only the full stack blocks it. It then unwinds the stack in reverse order, with a wrong-order retirement placed in the middle.

// File: rtl/irq_prio_pkg.sv
// Package irq_prio_pkg
// Shared constants and priority helper functions for the priority unit.
// Assumes 8-bit priorities and 10-bit interrupt IDs.
package irq_prio_pkg;
    localparam int PRIO_W = 8;
    localparam int ID_W = 10;
    localparam logic [ID_W-1:0] ID_NONE = 10'd1023;
    localparam logic [PRIO_W-1:0] PRIO_IDLE = 8'hFF;

    // Mask that keeps the implemented upper bits of a priority.
    function automatic logic [PRIO_W-1:0] impl_mask(input int bits);
        return 8'hFF << (PRIO_W - bits);
    endfunction

    // Mask that keeps the group field for a given binary point.
    function automatic logic [PRIO_W-1:0] group_mask(input logic [2:0] bp);
        return 8'hFF << bp;
    endfunction
endpackage

// File: rtl/irq_prio_cmp.sv
// Module irq_prio_cmp
// Combinational decision: truncates the candidate priority, applies the
// priority mask, and applies the group-priority preemption test against
// the running priority. Assumes run_prio is already truncated.
module irq_prio_cmp
    import irq_prio_pkg::*;
#(
    parameter int PRIO_BITS = 5
) (
    input  logic              cand_valid,
    input  logic [PRIO_W-1:0] cand_prio,
    input  logic [PRIO_W-1:0] prio_mask,
    input  logic [2:0]        bin_point,
    input  logic [PRIO_W-1:0] run_prio,
    input  logic              run_idle,
    input  logic              stack_full,
    output logic              signal,
    output logic [PRIO_W-1:0] cand_trunc
);
    localparam logic [PRIO_W-1:0] IMASK = impl_mask(PRIO_BITS);

    logic [PRIO_W-1:0] mask_trunc;
    logic [PRIO_W-1:0] gmask;
    logic              pass_mask;
    logic              pass_preempt;

    // Truncate the inputs, then form the mask and preemption tests.
    always_comb begin
        cand_trunc   = cand_prio & IMASK;
        mask_trunc   = prio_mask & IMASK;
        gmask        = group_mask(bin_point);
        pass_mask    = cand_trunc < mask_trunc;
        pass_preempt = run_idle || ((cand_trunc & gmask) < (run_prio & gmask));
        signal       = cand_valid && pass_mask && pass_preempt && !stack_full;
    end
endmodule

// File: rtl/irq_prio_stack.sv
// Module irq_prio_stack
// Last-in-first-out stack of active priorities and IDs. The top entry
// gives the running priority. Assumes the caller never pushes when the
// stack is full and never pops when it is empty.
module irq_prio_stack
    import irq_prio_pkg::*;
#(
    parameter int DEPTH = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              push,
    input  logic [PRIO_W-1:0] push_prio,
    input  logic [ID_W-1:0]   push_id,
    input  logic              pop,
    output logic [PRIO_W-1:0] top_prio,
    output logic [ID_W-1:0]   top_id,
    output logic              empty,
    output logic              full
);
    localparam int IW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int CW = $clog2(DEPTH + 1);

    logic [PRIO_W-1:0] prio_q [DEPTH];
    logic [ID_W-1:0]   id_q   [DEPTH];
    logic [CW-1:0]     cnt;
    logic [IW-1:0]     top_idx;
    logic [IW-1:0]     wr_idx;

    // Derive the occupancy flags and the read and write slots.
    always_comb begin
        empty   = (cnt == '0);
        full    = (cnt == CW'(DEPTH));
        top_idx = IW'(cnt - CW'(1));
        wr_idx  = IW'(cnt);
        top_prio = empty ? PRIO_IDLE : prio_q[top_idx];
        top_id   = empty ? ID_NONE : id_q[top_idx];
    end

    // Store pushed entries and track the occupancy count.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt <= '0;
            for (int i = 0; i < DEPTH; i++) begin
                prio_q[i] <= PRIO_IDLE;
                id_q[i]   <= ID_NONE;
            end
        end else if (push) begin
            prio_q[wr_idx] <= push_prio;
            id_q[wr_idx]   <= push_id;
            cnt            <= cnt + CW'(1);
        end else if (pop) begin
            cnt <= cnt - CW'(1);
        end
    end

    a_r8_no_overflow: assert property (@(posedge clk) disable iff (!rst_n)
        push |-> !full);
    a_r11_no_underflow: assert property (@(posedge clk) disable iff (!rst_n)
        pop |-> !empty);
    a_r9_pop_lowers_count: assert property (@(posedge clk) disable iff (!rst_n)
        (pop && !push) |=> (cnt == $past(cnt) - CW'(1)));
endmodule

// File: rtl/irq_prio_unit.sv
// Module irq_prio_unit
// Per-processor priority and preemption unit. It signals the candidate
// when it passes the mask and preemption tests, pushes it on acknowledge,
// and pops it on a matching end-of-interrupt. Assumes the candidate
// inputs stay stable for the cycle of the acknowledge.
module irq_prio_unit
    import irq_prio_pkg::*;
#(
    parameter int PRIO_BITS   = 5,
    parameter int STACK_DEPTH = 8
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        cand_valid,
    input  logic [7:0]  cand_prio,
    input  logic [9:0]  cand_id,
    input  logic [7:0]  prio_mask,
    input  logic [2:0]  bin_point,
    input  logic        ack,
    input  logic        eoi,
    input  logic [9:0]  eoi_id,
    output logic        irq_req,
    output logic [9:0]  ack_id,
    output logic [7:0]  running_prio,
    output logic        eoi_err
);
    logic [PRIO_W-1:0] cand_trunc;
    logic [ID_W-1:0]   top_id;
    logic              empty;
    logic              full;
    logic              do_push;
    logic              eoi_hit;

    irq_prio_cmp #(.PRIO_BITS(PRIO_BITS)) u_cmp (
        .cand_valid (cand_valid),
        .cand_prio  (cand_prio),
        .prio_mask  (prio_mask),
        .bin_point  (bin_point),
        .run_prio   (running_prio),
        .run_idle   (empty),
        .stack_full (full),
        .signal     (irq_req),
        .cand_trunc (cand_trunc)
    );

    irq_prio_stack #(.DEPTH(STACK_DEPTH)) u_stack (
        .clk       (clk),
        .rst_n     (rst_n),
        .push      (do_push),
        .push_prio (cand_trunc),
        .push_id   (cand_id),
        .pop       (eoi_hit),
        .top_prio  (running_prio),
        .top_id    (top_id),
        .empty     (empty),
        .full      (full)
    );

    // Decide between the push and the pop; end-of-interrupt takes precedence.
    always_comb begin
        eoi_hit = eoi && !empty && (eoi_id == top_id);
        do_push = ack && !eoi && irq_req;
    end

    // Register the acknowledge result and the end-of-interrupt error pulse.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ack_id  <= ID_NONE;
            eoi_err <= 1'b0;
        end else begin
            eoi_err <= eoi && !eoi_hit;
            if (ack) begin
                ack_id <= do_push ? cand_id : ID_NONE;
            end
        end
    end

    a_r3_req_needs_valid: assert property (@(posedge clk) disable iff (!rst_n)
        irq_req |-> (cand_valid && ((cand_prio & impl_mask(PRIO_BITS)) < (prio_mask & impl_mask(PRIO_BITS)))));
    a_r6_ack_sets_running: assert property (@(posedge clk) disable iff (!rst_n)
        (ack && irq_req && !eoi) |=> (running_prio == $past(cand_prio & impl_mask(PRIO_BITS))));
    a_r7_spurious_keeps_running: assert property (@(posedge clk) disable iff (!rst_n)
        (ack && !irq_req && !eoi) |=> ($stable(running_prio) && ack_id == ID_NONE));
    a_r11_empty_eoi_flags: assert property (@(posedge clk) disable iff (!rst_n)
        (eoi && running_prio == PRIO_IDLE) |=> eoi_err);
    a_r8_full_blocks: assert property (@(posedge clk) disable iff (!rst_n)
        full |-> !irq_req);
endmodule

// File: tb/tb_irq_prio_unit.sv
module tb_irq_prio_unit;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       cand_valid = 1'b0;
    logic [7:0] cand_prio = 8'hFF;
    logic [9:0] cand_id = '0;
    logic [7:0] prio_mask = 8'hFF;
    logic [2:0] bin_point = 3'd0;
    logic       ack = 1'b0;
    logic       eoi = 1'b0;
    logic [9:0] eoi_id = '0;
    logic       irq_req;
    logic [9:0] ack_id;
    logic [7:0] running_prio;
    logic       eoi_err;

    int n_checks = 0;
    int n_errors = 0;
    bit done = 1'b0;

    irq_prio_unit dut (
        .clk(clk), .rst_n(rst_n), .cand_valid(cand_valid), .cand_prio(cand_prio),
        .cand_id(cand_id), .prio_mask(prio_mask), .bin_point(bin_point),
        .ack(ack), .eoi(eoi), .eoi_id(eoi_id), .irq_req(irq_req),
        .ack_id(ack_id), .running_prio(running_prio), .eoi_err(eoi_err)
    );

    always #10 clk = ~clk;

    task automatic chk(input string req, input int act, input int exp);
        n_checks++;
        if (act != exp) begin
            n_errors++;
            $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic step();
        @(posedge clk);
        @(negedge clk);
        #1;
    endtask

    task automatic set_cand(input logic v, input logic [7:0] p, input logic [9:0] id);
        cand_valid = v; cand_prio = p; cand_id = id; #1;
    endtask

    task automatic do_ack();
        ack = 1'b1; step(); ack = 1'b0; #1;
    endtask

    task automatic do_eoi(input logic [9:0] id);
        eoi = 1'b1; eoi_id = id; step(); eoi = 1'b0; #1;
    endtask

    task automatic t_reset();
        chk("R1 irq_req", irq_req, 0);
        chk("R1 running_prio", running_prio, 8'hFF);
        chk("R1 ack_id", ack_id, 1023);
        chk("R1 eoi_err", eoi_err, 0);
    endtask

    task automatic t_mask();
        prio_mask = 8'h40; bin_point = 3'd3;
        set_cand(1'b1, 8'h47, 10'd3);
        chk("R3 equal truncated blocks", irq_req, 0);
        set_cand(1'b1, 8'h3F, 10'd3);
        chk("R2 low bits ignored, passes mask", irq_req, 1);
        set_cand(1'b0, 8'h3F, 10'd3);
        chk("R4 idle follows cand_valid", irq_req, 0);
    endtask

    task automatic t_ack_preempt();
        set_cand(1'b1, 8'h3F, 10'd5);
        do_ack();
        chk("R6 ack_id", ack_id, 5);
        chk("R2 R6 running truncated", running_prio, 8'h38);
        set_cand(1'b1, 8'h30, 10'd6);
        chk("R5 higher group preempts", irq_req, 1);
        bin_point = 3'd4; #1;
        chk("R5 same group no preempt", irq_req, 0);
        set_cand(1'b1, 8'h28, 10'd6);
        chk("R5 higher group bp4", irq_req, 1);
        bin_point = 3'd3;
        set_cand(1'b1, 8'h3A, 10'd6);
        chk("R5 equal truncated no preempt", irq_req, 0);
        do_ack();
        chk("R7 spurious id", ack_id, 1023);
        chk("R7 running unchanged", running_prio, 8'h38);
    endtask

    task automatic t_eoi();
        eoi = 1'b1; eoi_id = 10'd7; step();
        chk("R10 eoi_err", eoi_err, 1);
        chk("R10 running unchanged", running_prio, 8'h38);
        eoi_id = 10'd5; step(); eoi = 1'b0; #1;
        chk("R9 no error", eoi_err, 0);
        chk("R9 running idle", running_prio, 8'hFF);
        do_eoi(10'd5);
        chk("R11 eoi_err on empty", eoi_err, 1);
        chk("R11 running idle", running_prio, 8'hFF);
        step();
        chk("R10 eoi_err is a pulse", eoi_err, 0);
    endtask

    task automatic t_full();
        prio_mask = 8'hFF; bin_point = 3'd0;
        for (int k = 0; k < 8; k++) begin
            set_cand(1'b1, 8'(8'h40 - 8 * k), 10'(k + 1));
            do_ack();
        end
        chk("R8 eight pushed", running_prio, 8'h08);
        chk("R8 last id", ack_id, 8);
        set_cand(1'b1, 8'h00, 10'd20);
        chk("R8 full blocks", irq_req, 0);
        do_ack();
        chk("R8 ack returns 1023", ack_id, 1023);
        do_eoi(10'd7);
        chk("R10 wrong order rejected", eoi_err, 1);
        chk("R10 stack kept", running_prio, 8'h08);
        for (int k = 8; k >= 1; k--) begin
            do_eoi(10'(k));
            chk("R9 unwind error", eoi_err, 0);
            chk("R9 unwind running", running_prio, (k == 1) ? 8'hFF : (8'h40 - 8 * (k - 2)));
        end
    endtask

    task automatic t_both();
        set_cand(1'b1, 8'h10, 10'd9);
        do_ack();
        chk("R6 push before combo", running_prio, 8'h10);
        set_cand(1'b1, 8'h08, 10'd10);
        chk("R5 combo candidate preempts", irq_req, 1);
        ack = 1'b1; eoi = 1'b1; eoi_id = 10'd9; step();
        ack = 1'b0; eoi = 1'b0; #1;
        chk("R12 ack ignored", ack_id, 1023);
        chk("R12 eoi popped", running_prio, 8'hFF);
        chk("R12 no error", eoi_err, 0);
    endtask

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk); #1;
        t_reset();
        rst_n = 1'b1;
        t_mask();
        t_ack_preempt();
        t_eoi();
        t_full();
        t_both();
        done = 1'b1;
    end

    initial begin
        fork
            wait (done);
            begin
                repeat (5000) @(posedge clk);
                n_checks++;
                n_errors++;
                $display("FAIL watchdog: actual=timeout expected=completion");
            end
        join_any
        $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
        $finish;
    end
endmodule